// File: doc/BRIEF.md
# ECC error capture register

This block sits next to a memory controller's ECC checker and keeps a record of the first memory error it reports. The checker sends a one-cycle single-bit (corrected) or multi-bit (uncorrectable) error pulse. With the pulse it sends the failing address and the 8-bit syndrome. The block holds that event in one 32-bit status and control word until software acknowledges it. Any error events that arrive while a capture is held are dropped.

The same word carries three writable controls:

- an enable that turns a held single-bit error into a non-maskable interrupt request;
- an enable that turns a held multi-bit error into a system-error request;
- a switch that stops the scrub write-back after a corrected read.

The request outputs are levels. Each stays high for as long as its error is held and its enable is set.

Software reads the whole word on `reg_rdata`. It writes the controls and acknowledges a capture with one write on `reg_wr` / `reg_wdata`. The error flags are write-one-to-clear.

Top module: `ecc_err_capture`

## Requirements
- R1: After a synchronous active-low reset, `reg_rdata` is all zeros, `nmi_req` and `serr_req` are 0, and `scrub_en` is 1.
- R2: A single-bit event captured at a clock edge sets bit 0 (single-bit flag) from the next cycle on. Bits 30:12 then hold `err_addr[31:13]` and bits 11:4 hold `err_syn`.
- R3: A multi-bit event captured at a clock edge sets bit 1 (multi-bit flag) from the next cycle on, with the same address and syndrome fields as R2.
- R4: While bit 0 or bit 1 is set, new events are ignored. The flags, the address field and the syndrome field keep their values.
- R5: If a single-bit and a multi-bit event arrive in the same cycle while no flag is set, only the multi-bit flag is set. The two flags are never set together.
- R6: A write with a 1 in bit 0 or bit 1 clears that flag. A 0 there leaves it unchanged. Once both flags are clear, the next event is captured.
- R7: Bits 31, 3 and 2 are read/write control bits, loaded by every write. Writes to bits 30:4 have no effect on them.
- R8: `nmi_req` is 1 exactly when bit 0 and bit 2 are both set.
- R9: `serr_req` is 1 exactly when bit 1 and bit 3 are both set.
- R10: `scrub_en` is 1 exactly when bit 31 (scrub disable) is 0.
- R11: An event that arrives in the same cycle as a register write, while no flag is set, is still captured, and the write's control bits still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sbe_evt | input | 1 | Single-bit (corrected) error pulse |
| mbe_evt | input | 1 | Multi-bit (uncorrectable) error pulse |
| err_addr | input | 32 | Failing physical address, valid with a pulse |
| err_syn | input | 8 | ECC syndrome, valid with a pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value |
| nmi_req | output | 1 | Non-maskable interrupt request |
| serr_req | output | 1 | System-error request |
| scrub_en | output | 1 | Scrub write-back allowed after a corrected read |

## Verification
The hardest cases to reach from the ports are the collisions. One is an event that lands in the same cycle as the write that clears a held flag. Another is an event that lands in the same cycle as a control write while no flag is held. A third is a single-bit and a multi-bit pulse arriving together. The stimulus drives each of these collisions on purpose. It also runs a long stretch of pseudo-random pulses, addresses and writes. A behavioural model predicts the read word and the three outputs after every edge. That model decides which event wins, and whether a clear lands before or after a capture.

// File: rtl/ecc_cap_pkg.sv
// Shared layout of the error capture word. Bit positions are fixed because
// software decodes them.
package ecc_cap_pkg;
    localparam int REG_W   = 32;
    localparam int SYN_W   = 8;
    localparam int CAP_W   = 19;
    localparam int B_SBE   = 0;
    localparam int B_MBE   = 1;
    localparam int B_NMIEN = 2;
    localparam int B_SEREN = 3;
    localparam int B_SYN   = 4;
    localparam int B_ADDR  = B_SYN + SYN_W;
    localparam int B_SDIS  = REG_W - 1;

    // Captured error record
    typedef struct packed {
        logic             sbe;
        logic             mbe;
        logic [CAP_W-1:0] addr;
        logic [SYN_W-1:0] syn;
    } cap_rec_t;

    // Writable control bits
    typedef struct packed {
        logic sdis;
        logic seren;
        logic nmien;
    } ctrl_t;
endpackage

// File: rtl/ecc_ctrl_bits.sv
// Control bit storage: scrub disable and the two request enables.
// Assumes one write strobe; every write loads all three bits.
module ecc_ctrl_bits
    import ecc_cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl
);
    // Load the control bits on a write, clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr) begin
            ctrl.sdis  <= wdata[B_SDIS];
            ctrl.seren <= wdata[B_SEREN];
            ctrl.nmien <= wdata[B_NMIEN];
        end
    end

    // R7
    ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr) && $past(rst_n) |-> ctrl.sdis == $past(wdata[B_SDIS]));
endmodule

// File: rtl/ecc_err_latch.sv
// First-error-wins capture of one error record.
// Assumes event pulses are qualified by the caller. A multi-bit event takes
// priority over a single-bit one in the same cycle. A capture wins over a
// flag clear in the same cycle (this can only happen with both flags clear).
module ecc_err_latch
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sbe_evt,
    input  logic              mbe_evt,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [SYN_W-1:0]  err_syn,
    input  logic              wr,
    input  logic [1:0]        clr_bits,
    output cap_rec_t          rec
);
    localparam int ADDR_LO = ADDR_W - CAP_W;

    logic held;
    logic take;
    assign held = rec.sbe | rec.mbe;
    assign take = !held && (sbe_evt || mbe_evt);

    // Capture a new event when idle, otherwise apply write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec <= '0;
        end else if (take) begin
            rec.mbe  <= mbe_evt;
            rec.sbe  <= !mbe_evt;
            rec.addr <= err_addr[ADDR_W-1:ADDR_LO];
            rec.syn  <= err_syn;
        end else if (wr) begin
            if (clr_bits[0]) rec.sbe <= 1'b0;
            if (clr_bits[1]) rec.mbe <= 1'b0;
        end
    end

    // R5
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rec.sbe && rec.mbe));

    // R4
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(held) |-> $stable(rec.addr) && $stable(rec.syn));

    // R2
    sbe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $rose(rec.sbe) |-> $past(sbe_evt && !mbe_evt));

    // R6
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr && clr_bits == 2'b11 && held) |-> !rec.sbe && !rec.mbe);
endmodule

// File: rtl/ecc_err_capture.sv
// Top of the ECC error capture register. It assembles the 32-bit word from
// the held error record and the control bits, and drives the request levels.
// Assumes ADDR_W >= 19; the upper 19 address bits are kept.
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sbe_evt,
    input  logic              mbe_evt,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [7:0]        err_syn,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              nmi_req,
    output logic              serr_req,
    output logic              scrub_en
);
    cap_rec_t rec;
    ctrl_t    ctrl;

    ecc_ctrl_bits u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .ctrl  (ctrl)
    );

    ecc_err_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .sbe_evt  (sbe_evt),
        .mbe_evt  (mbe_evt),
        .err_addr (err_addr),
        .err_syn  (err_syn),
        .wr       (reg_wr),
        .clr_bits ({reg_wdata[B_MBE], reg_wdata[B_SBE]}),
        .rec      (rec)
    );

    // Pack the read word in its software-visible layout.
    always_comb begin
        reg_rdata                           = '0;
        reg_rdata[B_SDIS]                   = ctrl.sdis;
        reg_rdata[B_ADDR +: CAP_W]          = rec.addr;
        reg_rdata[B_SYN +: SYN_W]           = rec.syn;
        reg_rdata[B_SEREN]                  = ctrl.seren;
        reg_rdata[B_NMIEN]                  = ctrl.nmien;
        reg_rdata[B_MBE]                    = rec.mbe;
        reg_rdata[B_SBE]                    = rec.sbe;
    end

    // Request levels, gated by their enables.
    always_comb begin
        nmi_req  = rec.sbe & ctrl.nmien;
        serr_req = rec.mbe & ctrl.seren;
        scrub_en = !ctrl.sdis;
    end

    // R8
    nmi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> reg_rdata[B_SBE] && !serr_req);

    // R3
    mbe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $rose(reg_rdata[B_MBE]) |-> $past(mbe_evt));
endmodule

// File: tb/sim_ecc_err_capture.sv
module sim_ecc_err_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sbe_evt = 1'b0, mbe_evt = 1'b0, reg_wr = 1'b0;
    logic [31:0] err_addr = '0, reg_wdata = '0;
    logic [7:0]  err_syn = '0;
    logic [31:0] reg_rdata;
    logic        nmi_req, serr_req, scrub_en;

    int vectors = 0;
    int fails = 0;
    bit started = 0;

    // reference model state
    bit          m_sbe, m_mbe, m_nmien, m_seren, m_sdis;
    logic [18:0] m_addr;
    logic [7:0]  m_syn;

    always #4 clk = ~clk;

    ecc_err_capture u0 (
        .clk(clk), .rst_n(rst_n), .sbe_evt(sbe_evt), .mbe_evt(mbe_evt),
        .err_addr(err_addr), .err_syn(err_syn), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_req(nmi_req),
        .serr_req(serr_req), .scrub_en(scrub_en)
    );

    // model update at each edge from the inputs held since the last negedge
    always @(posedge clk) begin
        bit cap;
        started <= 1;
        if (!rst_n) begin
            m_sbe = 0; m_mbe = 0; m_nmien = 0; m_seren = 0; m_sdis = 0;
            m_addr = '0; m_syn = '0;
        end else begin
            cap = !m_sbe && !m_mbe && (sbe_evt || mbe_evt);
            if (reg_wr) begin
                if (reg_wdata[0]) m_sbe = 0;
                if (reg_wdata[1]) m_mbe = 0;
                m_sdis = reg_wdata[31]; m_seren = reg_wdata[3]; m_nmien = reg_wdata[2];
            end
            if (cap) begin
                m_mbe = mbe_evt; m_sbe = !mbe_evt;
                m_addr = err_addr[31:13]; m_syn = err_syn;
            end
        end
    end

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every output to the model on each falling edge
    always @(negedge clk) begin
        if (started) begin
            cmp("R2 sbe flag", 32'(reg_rdata[0]), 32'(m_sbe));
            cmp("R3 mbe flag", 32'(reg_rdata[1]), 32'(m_mbe));
            cmp("R4 addr", 32'(reg_rdata[30:12]), 32'(m_addr));
            cmp("R4 syn", 32'(reg_rdata[11:4]), 32'(m_syn));
            cmp("R7 ctrl", {29'd0, reg_rdata[31], reg_rdata[3], reg_rdata[2]},
                {29'd0, m_sdis, m_seren, m_nmien});
            cmp("R8 nmi", 32'(nmi_req), 32'(m_sbe & m_nmien));
            cmp("R9 serr", 32'(serr_req), 32'(m_mbe & m_seren));
            cmp("R10 scrub", 32'(scrub_en), 32'(!m_sdis));
        end
    end

    task automatic cyc(input bit s, input bit m, input logic [31:0] a, input logic [7:0] y,
                       input bit w, input logic [31:0] wd);
        @(negedge clk);
        #1;
        sbe_evt = s; mbe_evt = m; err_addr = a; err_syn = y; reg_wr = w; reg_wdata = wd;
    endtask

    task automatic idle();
        cyc(0, 0, 32'h0, 8'h0, 0, 32'h0);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        lfsr = 32'hACE1_1357;
        repeat (3) @(negedge clk);
        // R1: reset values
        cmp("R1 rdata", reg_rdata, 32'h0);
        cmp("R1 scrub", 32'(scrub_en), 32'h1);
        rst_n = 1'b1;
        idle();
        // R7: enables, junk in read-only bits ignored
        cyc(0, 0, 0, 0, 1, 32'h7FFF_FFF0 | 32'h0000_000C);
        // R2: single-bit capture, NMI raised
        cyc(1, 0, 32'hDEAD_BEEF, 8'h5A, 0, 0);
        idle();
        @(negedge clk);
        cmp("R2 word", reg_rdata, {1'b0, 19'(32'hDEAD_BEEF >> 13), 8'h5A, 4'b1101});
        // R4: later events ignored
        cyc(0, 1, 32'h1234_5678, 8'hFF, 0, 0);
        cyc(1, 0, 32'h0, 8'h01, 0, 0);
        idle();
        // R6: writing 0 to flags does nothing, then 1 clears while event collides
        cyc(0, 0, 0, 0, 1, 32'h0000_000C);
        cyc(0, 1, 32'hFFFF_FFFF, 8'h33, 1, 32'h0000_000F);
        idle();
        @(negedge clk);
        cmp("R6 cleared", 32'(reg_rdata[1:0]), 32'h0);
        // R5: simultaneous events, MBE wins, SERR raised
        cyc(1, 1, 32'h8000_2000, 8'hC3, 0, 0);
        idle();
        @(negedge clk);
        cmp("R5 mbe only", 32'(reg_rdata[1:0]), 32'h2);
        cmp("R9 serr", 32'(serr_req), 32'h1);
        cyc(0, 0, 0, 0, 1, 32'h8000_0003);
        idle();
        @(negedge clk);
        cmp("R10 scrub off", 32'(scrub_en), 32'h0);
        // R11: event together with a control write while idle
        cyc(1, 0, 32'h0040_0000, 8'h77, 1, 32'h0000_0004);
        idle();
        @(negedge clk);
        cmp("R11 captured", 32'(reg_rdata[0]), 32'h1);
        cmp("R11 ctrl", {reg_rdata[31], reg_rdata[3:2]}, 32'h1);
        // random stretch
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cyc(lfsr[3:0] == 4'h1, lfsr[7:4] == 4'h2, {lfsr[15:0], lfsr[31:16]}, lfsr[23:16],
                lfsr[11:9] == 3'b101, {lfsr[31], 27'(lfsr), lfsr[3:0]});
        end
        // R1: reset mid-run
        rst_n = 1'b0;
        idle();
        idle();
        @(negedge clk);
        cmp("R1 rdata again", reg_rdata, 32'h0);
        rst_n = 1'b1;
        idle();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule